// File: doc/BRIEF.md
# Pipelined Angle Sensor Poller

This block is the host side of a serial link to a magnetic angle sensor. It acts as an SPI master in mode 0, sends 16-bit command frames back to back, and pairs each incoming frame with the command sent one frame earlier. The sensor always answers a command during the following frame. While `run` is high the block keeps issuing angle reads. When `run` falls it sends one trailing no-operation frame, so that the reply to the last real command is collected, and then it goes idle.

Every reply it checks is tested for even parity over all 16 bits and for the sensor's sticky error flag. A failed reply is discarded and reported on `link_err`. The block then sends a clear-error command and checks that the sensor answers it with an all-zero word. A good angle reply yields a 10-bit angle, two alarm bits and a major-fault indication. When `avg_en` is set, four good angles are combined into one output. The average is taken relative to the first sample of the group, so a group that straddles the 1023/0 boundary averages correctly.

SCK half period, select-to-clock setup and the minimum select-high gap are parameters counted in system clocks.

Top module: `angle_poll_master`

## Requirements
- R1: Each frame is exactly 16 SCK rising edges, most significant bit first. SCK rests low whenever select is high. MOSI changes only after falling SCK edges, and MISO is sampled on rising edges.
- R2: Between frames, select stays high for at least `GAP` clocks. From select falling to the first SCK rise there are at least `SETUP` clocks.
- R3: The command words are fixed. An angle read is 0xFFFF: read bit 15, address 0x3FFF in bits 14:1, and an even-parity bit 0. A clear-error command is 0xE700, a read of address 0x3380. A no-operation frame is 0x0000.
- R4: No frame is sent while `run` is low and the block is idle. While `run` is high, angle reads follow each other with no idle gap beyond `GAP`. The reply received in the first frame after idle is ignored: it produces neither `angle_valid` nor `link_err`.
- R5: When `run` falls, the frame in progress completes. If the last frame sent was a read or a clear, exactly one 0x0000 frame follows, and then select stays high. A pending clear is sent first.
- R6: A good reply to an angle read is decoded as follows: angle = bits 11:2, alarm-low = bit 15, alarm-high = bit 14, and major fault = both alarms set. With averaging off, this produces a one-cycle `angle_valid` pulse. The outputs hold their values until the next pulse.
- R7: A checked reply whose 16 bits have odd parity is discarded and pulses `link_err` for one cycle.
- R8: A checked reply with bit 1 set (the sensor error flag) is discarded and pulses `link_err`. If that reply arrives while the most recently sent frame is not a clear, the next frame sent is 0xE700. If the most recently sent frame is already a clear, no second clear is queued.
- R9: The reply to a clear must be 0x0000. Any other good-parity word pulses `link_err` and queues another clear.
- R10: With `avg_en` high, four good angle replies give one `angle_valid` pulse. The output angle is (first + floor(sum of the four signed differences to first, each wrapped into -512..511, divided by 4)) mod 1024. Each alarm output is the OR of that alarm over the group.
- R11: After reset, select is high, SCK is low, and `busy`, `angle_valid`, `link_err` and `angle` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Keep polling while high |
| avg_en | input | 1 | Average groups of four angles |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Sensor select, active low |
| mosi | output | 1 | Command bits to the sensor |
| miso | input | 1 | Reply bits from the sensor |
| angle_valid | output | 1 | One-cycle pulse, new angle result |
| angle | output | 10 | Angle result |
| alarm_lo | output | 1 | Field-too-weak alarm of the result |
| alarm_hi | output | 1 | Field-too-strong alarm of the result |
| major_fault | output | 1 | Both alarms set |
| link_err | output | 1 | One-cycle pulse, a checked reply failed |
| busy | output | 1 | A frame or the inter-frame gap is in progress |

## Verification
The hardest situation to reach is the sticky error flag colliding with the one-frame lag. When the error is discovered, another read is already in flight, and its reply also carries the flag. That reply arrives during the clear frame, and it must be reported without queuing a second clear. The bench's sensor model plays a scripted list of reply words, one per select-low period, so that flagged replies, corrupted parity and a non-zero answer to a clear each land in a chosen frame. The words sent on MOSI are then compared frame by frame with the expected command sequence.

// File: rtl/angle_poll_master.sv
module angle_poll_master #(
  parameter int DIV   = 2,
  parameter int SETUP = 3,
  parameter int GAP   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       avg_en,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso,
  output logic       angle_valid,
  output logic [9:0] angle,
  output logic       alarm_lo,
  output logic       alarm_hi,
  output logic       major_fault,
  output logic       link_err,
  output logic       busy
);
  localparam int FW   = 16;
  localparam int AW   = 10;
  localparam int NAVG = 4;
  localparam int SH   = $clog2(NAVG);
  localparam int SW   = AW + SH;
  localparam int TMAX = (DIV > SETUP) ? ((DIV > GAP) ? DIV : GAP) : ((SETUP > GAP) ? SETUP : GAP);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(FW + 1);

  typedef enum logic [1:0] {K_NONE, K_ANGLE, K_CLEAR, K_NOP} kind_t;
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP} state_t;

  function automatic logic [FW-1:0] cmd_word(input logic rd, input logic [FW-3:0] addr);
    return {rd, addr, ^{rd, addr}};
  endfunction

  state_t st;
  kind_t  last, chk, nxt;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [FW-1:0] tx, rx, nxt_word;
  logic need_clr;
  logic [AW-1:0] first, smp, dlt, avg_out;
  logic signed [SW-1:0] sum, sum_n, q;
  logic [SH-1:0] nsamp;
  logic alo_acc, ahi_acc, bad, tick;

  assign busy = (st != S_IDLE);
  assign mosi = tx[FW-1];
  assign tick = (cnt == CW'(DIV - 1));

  always_comb begin
    if (need_clr)                               nxt = K_CLEAR;
    else if (run)                               nxt = K_ANGLE;
    else if (last == K_ANGLE || last == K_CLEAR) nxt = K_NOP;
    else                                        nxt = K_NONE;
  end

  assign nxt_word = (nxt == K_ANGLE) ? cmd_word(1'b1, 14'h3FFF) :
                    (nxt == K_CLEAR) ? cmd_word(1'b1, 14'h3380) : '0;

  assign bad     = (^rx) || rx[1] || (chk == K_CLEAR && rx[FW-1:2] != '0);
  assign smp     = rx[AW+1:2];
  assign dlt     = smp - first;
  assign sum_n   = sum + $signed({{SH{dlt[AW-1]}}, dlt});
  assign q       = sum_n >>> SH;
  assign avg_out = first + q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sck <= 1'b0; cs_n <= 1'b1;
      tx <= '0; rx <= '0; chk <= K_NONE; last <= K_NONE; need_clr <= 1'b0;
      angle_valid <= 1'b0; angle <= '0; alarm_lo <= 1'b0; alarm_hi <= 1'b0;
      major_fault <= 1'b0; link_err <= 1'b0;
      first <= '0; sum <= '0; nsamp <= '0; alo_acc <= 1'b0; ahi_acc <= 1'b0;
    end else begin
      angle_valid <= 1'b0;
      link_err    <= 1'b0;
      if (!avg_en || st == S_IDLE) nsamp <= '0;
      case (st)
        S_IDLE, S_GAP: begin
          if (st == S_IDLE || cnt == CW'(GAP - 1)) begin
            cnt <= '0;
            if (nxt != K_NONE) begin
              st <= S_SETUP; cs_n <= 1'b0; tx <= nxt_word;
              chk <= last; last <= nxt; bitn <= '0;
              if (nxt == K_CLEAR) need_clr <= 1'b0;
            end else begin
              st <= S_IDLE; last <= K_NONE;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_SETUP: begin
          if (cnt == CW'(SETUP - 1)) begin
            cnt <= '0; st <= S_SHIFT;
          end else cnt <= cnt + 1'b1;
        end
        S_SHIFT: begin
          if (tick) begin
            cnt <= '0;
            sck <= !sck;
            if (!sck) begin
              rx   <= {rx[FW-2:0], miso};
              bitn <= bitn + 1'b1;
            end else if (bitn == BW'(FW)) begin
              st <= S_HOLD;
              if (chk != K_NONE) begin
                if (bad) begin
                  link_err <= 1'b1;
                  if (last != K_CLEAR) need_clr <= 1'b1;
                end else if (chk == K_ANGLE) begin
                  if (!avg_en) begin
                    angle_valid <= 1'b1; angle <= smp;
                    alarm_lo <= rx[FW-1]; alarm_hi <= rx[FW-2];
                    major_fault <= rx[FW-1] & rx[FW-2];
                  end else if (nsamp == '0) begin
                    first <= smp; sum <= '0; nsamp <= 1'b1;
                    alo_acc <= rx[FW-1]; ahi_acc <= rx[FW-2];
                  end else begin
                    sum <= sum_n;
                    alo_acc <= alo_acc | rx[FW-1];
                    ahi_acc <= ahi_acc | rx[FW-2];
                    nsamp <= nsamp + 1'b1;
                    if (nsamp == SH'(NAVG - 1)) begin
                      angle_valid <= 1'b1; angle <= avg_out;
                      alarm_lo <= alo_acc | rx[FW-1];
                      alarm_hi <= ahi_acc | rx[FW-2];
                      major_fault <= (alo_acc | rx[FW-1]) & (ahi_acc | rx[FW-2]);
                    end
                  end
                end
              end
            end else tx <= {tx[FW-2:0], 1'b0};
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (tick) begin
            cnt <= '0; cs_n <= 1'b1; st <= S_GAP;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module angle_poll_master_chk #(
  parameter int SETUP = 3,
  parameter int GAP   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic angle_valid,
  input logic link_err,
  input logic busy
);
  logic [4:0]  rises;
  logic [15:0] hi_run, lo_run;
  logic        sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises <= '0; hi_run <= 16'(GAP); lo_run <= '0; sck_q <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        rises <= '0; lo_run <= '0;
        if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run != 16'hFFFF) lo_run <= lo_run + 1'b1;
        if (sck && !sck_q) rises <= rises + 1'b1;
      end
    end
  end

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R1
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> rises == 5'd16);
  // R2
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> hi_run >= 16'(GAP));
  // R2
  setup_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && !sck_q && rises == 5'd0) |-> lo_run >= 16'(SETUP));
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) angle_valid |=> !angle_valid);
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) link_err |=> !link_err);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
endmodule

bind angle_poll_master angle_poll_master_chk #(.SETUP(SETUP), .GAP(GAP)) u_chk (.*);

// File: tb/angle_poll_master_bench.sv
`timescale 1ns/1ps
module angle_poll_master_bench;
  localparam int DIV = 2, SETUP = 3, GAP = 4;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, avg_en = 1'b0, miso = 1'b0;
  logic sck, cs_n, mosi, angle_valid, alarm_lo, alarm_hi, major_fault, link_err, busy;
  logic [9:0] angle;

  angle_poll_master #(.DIV(DIV), .SETUP(SETUP), .GAP(GAP)) u_angle_poll_master (
    .clk(clk), .rst_n(rst_n), .run(run), .avg_en(avg_en), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .angle_valid(angle_valid), .angle(angle),
    .alarm_lo(alarm_lo), .alarm_hi(alarm_hi), .major_fault(major_fault),
    .link_err(link_err), .busy(busy));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rep [0:255];
  logic [15:0] sent [0:255];
  logic [9:0]  got_ang [0:255];
  logic [2:0]  got_flg [0:255];
  logic [9:0]  exp_ang [0:63];
  logic [2:0]  exp_flg [0:63];
  int rep_n = 0, rep_i = 0, sent_n = 0, got_n = 0, lerr_n = 0;
  logic [15:0] sh_out = '0, sh_in = '0;
  int hi_cnt = 0, lo_cnt = 0, rises = 0, gap_min = 1000, setup_min = 1000, len_bad = 0, idle_bad = 0;
  logic sck_p = 1'b0, cs_p = 1'b1;

  // sensor model: plays scripted replies, records commands
  always @(negedge cs_n) if (rst_n) begin
    sh_out = (rep_i < rep_n) ? rep[rep_i] : 16'h0000;
    rep_i++;
    miso = sh_out[15];
  end
  always @(negedge sck) if (rst_n && !cs_n) begin
    sh_out = sh_out << 1;
    miso = sh_out[15];
  end
  always @(posedge sck) if (rst_n) sh_in = {sh_in[14:0], mosi};
  always @(posedge cs_n) if (rst_n && sent_n < 256) begin
    sent[sent_n] = sh_in;
    sent_n++;
  end

  always @(negedge clk) if (rst_n) begin
    if (angle_valid && got_n < 256) begin
      got_ang[got_n] = angle;
      got_flg[got_n] = {alarm_lo, alarm_hi, major_fault};
      got_n++;
    end
    if (link_err) lerr_n++;
    if (cs_n && sck) idle_bad++;
    if (!cs_n && cs_p && hi_cnt < gap_min) gap_min = hi_cnt;
    if (cs_n && !cs_p && rises != 16) len_bad++;
    if (!cs_n && sck && !sck_p && rises == 0 && lo_cnt < setup_min) setup_min = lo_cnt;
    if (cs_n) begin hi_cnt++; lo_cnt = 0; rises = 0; end
    else begin
      hi_cnt = 0; lo_cnt++;
      if (sck && !sck_p) rises++;
    end
    sck_p = sck; cs_p = cs_n;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] mkraw(input logic [13:0] d, input logic ef);
    return {d, ef, ^{d, ef}};
  endfunction

  function automatic logic [15:0] mkrep(input logic lo, input logic hi, input logic [9:0] a);
    return mkraw({lo, hi, 2'b00, a}, 1'b0);
  endfunction

  task automatic new_test();
    rep_n = 0; rep_i = 0; sent_n = 0; got_n = 0; lerr_n = 0;
  endtask

  task automatic run_frames(input int n);
    run = 1'b1;
    repeat (n) @(negedge cs_n);
    run = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R11 reset state, R4 no frames while run low
    check("R11 cs_n", cs_n, 1);
    check("R11 sck", sck, 0);
    check("R11 busy", busy, 0);
    check("R11 angle", angle, 0);
    check("R11 angle_valid", angle_valid, 0);
    check("R4 no frame while idle", sent_n, 0);

    // R3 R4 R5 R6: plain polling over a sweep of angles
    begin
      int n = 24;
      new_test();
      avg_en = 1'b0;
      rep[0] = 16'h1234;
      for (int i = 1; i <= n; i++) begin
        logic [9:0] a;
        a = (i == 1) ? 10'd0 : (i == 2) ? 10'd1023 : 10'((i * 389 + 7) % 1024);
        rep[i] = mkrep(i % 3 == 0, i % 4 == 0, a);
        exp_ang[i-1] = a;
        exp_flg[i-1] = {i % 3 == 0, i % 4 == 0, i % 12 == 0};
      end
      rep_n = n + 1;
      run_frames(n);
      check("R4 first reply ignored, no link_err", lerr_n, 0);
      check("R6 result count", got_n, n);
      check("R5 frame count", sent_n, n + 1);
      for (int k = 0; k < n; k++) begin
        check("R3 angle read word", sent[k], 16'hFFFF);
        check("R6 angle", got_ang[k], exp_ang[k]);
        check("R6 alarms and major fault", got_flg[k], exp_flg[k]);
      end
      check("R5 trailing NOP word", sent[n], 16'h0000);
    end

    // R10 averaging with wrap-around groups
    begin
      int g_n = 8;
      new_test();
      avg_en = 1'b1;
      rep[0] = 16'h0FF0;
      for (int g = 0; g < g_n; g++) begin
        int base, s0, sum, qv, outv;
        logic lo, hi;
        base = (g == 0) ? 1022 : (g == 1) ? 1 : (g == 2) ? 511 : (g * 211 + 5) % 1024;
        sum = 0; s0 = 0; lo = 1'b0; hi = 1'b0;
        for (int j = 0; j < 4; j++) begin
          int s, d;
          s = (base + ((g + j * 3) % 9) - 4 + 1024) % 1024;
          if (j == 0) s0 = s;
          d = (s - s0 + 1024) % 1024;
          if (d >= 512) d = d - 1024;
          sum += d;
          lo |= ((g + j) % 7 == 0);
          hi |= ((g + j) % 5 == 0);
          rep[1 + 4 * g + j] = mkrep((g + j) % 7 == 0, (g + j) % 5 == 0, 10'(s));
        end
        qv = (sum >= 0) ? sum / 4 : -((-sum + 3) / 4);
        outv = ((s0 + qv) % 1024 + 1024) % 1024;
        exp_ang[g] = 10'(outv);
        exp_flg[g] = {lo, hi, lo & hi};
      end
      rep_n = 4 * g_n + 1;
      run_frames(4 * g_n);
      check("R10 averaged result count", got_n, g_n);
      for (int g = 0; g < g_n; g++) begin
        check("R10 averaged angle", got_ang[g], exp_ang[g]);
        check("R10 group alarms", got_flg[g], exp_flg[g]);
      end
      avg_en = 1'b0;
    end

    // R8 sticky error flag recovery
    new_test();
    rep[0] = 16'h1234;
    rep[1] = mkrep(1'b0, 1'b0, 10'd100);
    rep[2] = mkraw(14'h0155, 1'b1);
    rep[3] = mkraw(14'h0155, 1'b1);
    rep[4] = 16'h0000;
    rep[5] = mkrep(1'b0, 1'b0, 10'd200);
    rep[6] = mkrep(1'b0, 1'b0, 10'd300);
    rep_n = 7;
    run_frames(6);
    check("R8 frames sent", sent_n, 7);
    check("R8 f3 read", sent[2], 16'hFFFF);
    check("R8 clear after flag", sent[3], 16'hE700);
    check("R8 no second clear", sent[4], 16'hFFFF);
    check("R5 NOP after recovery", sent[6], 16'h0000);
    check("R8 link_err pulses", lerr_n, 2);
    check("R8 results", got_n, 3);
    check("R8 result 0", got_ang[0], 100);
    check("R8 result 1", got_ang[1], 200);
    check("R8 result 2", got_ang[2], 300);

    // R7 parity failure
    new_test();
    rep[0] = 16'h1234;
    rep[1] = mkrep(1'b0, 1'b0, 10'd11);
    rep[2] = mkrep(1'b0, 1'b0, 10'd22) ^ 16'h0020;
    rep[3] = mkrep(1'b0, 1'b0, 10'd33);
    rep[4] = 16'h0000;
    rep[5] = mkrep(1'b0, 1'b0, 10'd55);
    rep_n = 6;
    run_frames(5);
    check("R7 frames sent", sent_n, 6);
    check("R7 clear after bad parity", sent[3], 16'hE700);
    check("R7 read resumes", sent[4], 16'hFFFF);
    check("R7 link_err pulses", lerr_n, 1);
    check("R7 results", got_n, 3);
    check("R7 result 0", got_ang[0], 11);
    check("R7 corrupted word dropped", got_ang[1], 33);
    check("R7 result 2", got_ang[2], 55);

    // R9 clear answered with a non-zero word
    new_test();
    rep[0] = 16'h1234;
    rep[1] = mkraw(14'h0155, 1'b1);
    rep[2] = mkraw(14'h0155, 1'b1);
    rep[3] = 16'h0005;
    rep[4] = mkrep(1'b0, 1'b0, 10'd44);
    rep[5] = 16'h0000;
    rep[6] = mkrep(1'b0, 1'b0, 10'd66);
    rep_n = 7;
    run_frames(6);
    check("R9 frames sent", sent_n, 7);
    check("R9 first clear", sent[2], 16'hE700);
    check("R9 read after clear", sent[3], 16'hFFFF);
    check("R9 repeated clear", sent[4], 16'hE700);
    check("R9 trailing NOP", sent[6], 16'h0000);
    check("R9 link_err pulses", lerr_n, 3);
    check("R9 results", got_n, 2);
    check("R9 result 0", got_ang[0], 44);
    check("R9 result 1", got_ang[1], 66);

    // R1 R2 framing and timing over every frame above
    check("R1 16 rises per frame", len_bad, 0);
    check("R1 sck low while deselected", idle_bad, 0);
    check("R2 gap at least GAP", (gap_min >= GAP) ? 1 : 0, 1);
    check("R2 setup at least SETUP", (setup_min >= SETUP) ? 1 : 0, 1);

    summary();
    $finish;
  end
endmodule